// File: doc/BRIEF.md
# Banked Address Router with Local Paging

This block sits between one requester port and three kinds of target. Every 16-bit memory access that arrives is decoded: it goes to a peer device's control registers, to a peer device's memory window, or to the block's own paged local memory. It may also be dropped. The decision depends on who issued the access and on a 16-bit region-enable word. Each bit of that word marks one 4 KB region of the address space as windowed onto peers rather than mapped straight to local pages.

Local memory is a set of 256-word pages. The lowest pages hold fixed read-only contents and the rest are RAM that clears on reset. Accesses issued by the block's own device use the region windows. An access from the device named as the current bus-access holder is redirected into one local page picked by a configuration input. An access from any other requester has no effect.

Peer accesses use a single shared request/acknowledge channel that carries a device index. The consumer of that channel fans it out to up to 256 device slots. Slot 0 is always the block's own device.

Top module: `bank_router`

## Requirements
- R1: An access is windowed when bit `cfg_bank_en[addr[15:12]]` is set. A self access to a region whose bit is clear goes to local memory at page `addr[15:8]`, offset `addr[7:0]`.
- R2: A windowed self access with `addr[15:4] < cfg_dev_count` is forwarded with `peer_mem`=0, `peer_idx`=`addr[11:4]` and `peer_addr`=`{4'b0, addr[3:0]}`. Index 0 names the block's own device.
- R3: A windowed self access with `addr[15:12]` nonzero is handled by `addr[15:8]`. If `addr[15:8] < cfg_dev_count` it is forwarded with `peer_mem`=1, `peer_idx`=`addr[15:8]` and `peer_addr`=`addr[7:0]`. Otherwise it goes to local page `addr[15:8]`.
- R4: A self access is identified by `req_src == OWN_ID`. When it is not windowed, it reads and writes local memory at page `addr[15:8]` and offset `addr[7:0]`.
- R5: A non-self access with `req_src == cfg_bus_owner` goes to local page `cfg_page_sel` at offset `addr[7:0]`. The upper address byte is ignored.
- R6: Any other requester's write changes nothing, and its read returns 0.
- R7: Pages below `ROM_PAGES` are read-only and read `{page, offset} ^ ROM_SEED`. Writes to them are ignored.
- R8: RAM pages read 0 after reset and return the last value written.
- R9: Pages at or above `NUM_PAGES` read 0 and ignore writes.
- R10: A forwarded access raises `peer_req` in the cycle after acceptance and holds it, with stable fields, until `peer_ack`. `req_ready` stays low meanwhile. `rsp_valid` pulses in the cycle after the acknowledge, carrying `peer_rdata` for a read and 0 for a write.
- R11: A windowed self access in region 0 whose index `addr[15:4]` is at or above `cfg_dev_count` is dropped and reads 0.
- R12: Local and dropped accesses answer with a single `rsp_valid` pulse one cycle after acceptance, with no peer request. Writes answer with data 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_bank_en | input | 16 | Region window enables, one bit per 4 KB region |
| cfg_bus_owner | input | 16 | ID of the privileged bus-access holder |
| cfg_page_sel | input | 8 | Local page used for the bus-access holder |
| cfg_dev_count | input | 9 | Number of entries in the device list, self included |
| req_valid | input | 1 | Access request valid |
| req_ready | output | 1 | Router can accept an access |
| req_src | input | 16 | Requester device ID |
| req_addr | input | 16 | Access address |
| req_we | input | 1 | Write when 1, read when 0 |
| req_wdata | input | 16 | Write data |
| rsp_valid | output | 1 | One-cycle response pulse |
| rsp_rdata | output | 16 | Read data (0 for writes and dropped accesses) |
| peer_req | output | 1 | Peer access pending |
| peer_mem | output | 1 | 1 = peer memory window, 0 = peer control register |
| peer_idx | output | 8 | Target device index |
| peer_addr | output | 8 | Register number or memory offset in the peer |
| peer_we | output | 1 | Peer write |
| peer_wdata | output | 16 | Peer write data |
| peer_ack | input | 1 | Peer has completed the access |
| peer_rdata | input | 16 | Peer read data, valid with `peer_ack` |

## Verification
The assertions assume that the configuration inputs stay stable while an access is outstanding. They also assume that `peer_ack` only matters while `peer_req` is high and that the requester holds no access in flight across reset. The bench changes configuration only between completed accesses and issues one access at a time. Its peer model acknowledges only a raised request, two cycles after it appears, and drops the acknowledge after one cycle.

// File: rtl/rtr_pkg.sv
package rtr_pkg;

    localparam int RTR_AW = 16;
    localparam int RTR_DW = 16;
    localparam int RTR_BW = 8;

    typedef enum logic [1:0] {
        RT_LOCAL = 2'd0,
        RT_PCTRL = 2'd1,
        RT_PMEM  = 2'd2,
        RT_DROP  = 2'd3
    } route_e;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_WAIT = 1'b1
    } rtr_state_e;

    typedef struct packed {
        rtr_state_e        st;
        logic              rsp_valid;
        logic [RTR_DW-1:0] rsp_rdata;
        logic              peer_req;
        logic              peer_mem;
        logic [RTR_BW-1:0] peer_idx;
        logic [RTR_BW-1:0] peer_addr;
        logic              peer_we;
        logic [RTR_DW-1:0] peer_wdata;
    } rtr_regs_t;

endpackage

// File: rtl/rtr_decode.sv
module rtr_decode
    import rtr_pkg::*;
#(
    parameter logic [RTR_AW-1:0] OWN_ID = 16'h0003
) (
    input  logic [RTR_AW-1:0] src_id,
    input  logic [RTR_AW-1:0] addr,
    input  logic [15:0]       bank_en,
    input  logic [RTR_AW-1:0] bus_owner,
    input  logic [RTR_BW-1:0] page_sel,
    input  logic [8:0]        dev_count,
    output route_e            route,
    output logic [RTR_BW-1:0] page,
    output logic [RTR_BW-1:0] offset,
    output logic [RTR_BW-1:0] pidx,
    output logic [RTR_BW-1:0] paddr
);

    logic        windowed;
    logic [11:0] ctrl_idx;
    logic [11:0] count_ext;

    assign windowed  = bank_en[addr[15:12]];
    assign ctrl_idx  = addr[15:4];
    assign count_ext = {3'b000, dev_count};

    always_comb begin
        route  = RT_DROP;
        page   = addr[15:8];
        offset = addr[7:0];
        pidx   = addr[11:4];
        paddr  = {4'b0000, addr[3:0]};
        if (src_id == OWN_ID) begin
            if (!windowed) begin
                route = RT_LOCAL;
            end else if (ctrl_idx < count_ext) begin
                route = RT_PCTRL;
            end else if (addr[15:12] != 4'h0) begin
                if ({1'b0, addr[15:8]} < dev_count) begin
                    route = RT_PMEM;
                    pidx  = addr[15:8];
                    paddr = addr[7:0];
                end else begin
                    route = RT_LOCAL;
                end
            end else begin
                route = RT_DROP;
            end
        end else if (src_id == bus_owner) begin
            route = RT_LOCAL;
            page  = page_sel;
        end
    end

endmodule

// File: rtl/rtr_local_mem.sv
module rtr_local_mem
    import rtr_pkg::*;
#(
    parameter int                NUM_PAGES = 4,
    parameter int                ROM_PAGES = 1,
    parameter logic [RTR_DW-1:0] ROM_SEED  = 16'h5A3C
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [RTR_BW-1:0] page,
    input  logic [RTR_BW-1:0] offset,
    input  logic [RTR_DW-1:0] wdata,
    output logic [RTR_DW-1:0] rdata
);

    localparam int RAM_PAGES = NUM_PAGES - ROM_PAGES;
    localparam int PIDX_W    = (RAM_PAGES > 1) ? $clog2(RAM_PAGES) : 1;
    localparam int RAM_WORDS = (RAM_PAGES > 0 ? RAM_PAGES : 1) * 256;

    logic              in_range;
    logic              is_rom;
    logic [RTR_BW-1:0] ram_page;
    logic [RTR_DW-1:0] rom_word;
    logic [RTR_DW-1:0] ram_word;

    assign in_range = {1'b0, page} < 9'(NUM_PAGES);
    assign is_rom   = {1'b0, page} < 9'(ROM_PAGES);
    assign ram_page = page - RTR_BW'(ROM_PAGES);
    assign rom_word = RTR_DW'({page, offset}) ^ ROM_SEED;

    generate
        if (RAM_PAGES > 0) begin : g_ram
            logic [RTR_DW-1:0]      ram_q [RAM_WORDS];
            logic [PIDX_W+7:0]      ram_addr;

            assign ram_addr = {ram_page[PIDX_W-1:0], offset};
            assign ram_word = ram_q[ram_addr];

            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    for (int i = 0; i < RAM_WORDS; i++) begin
                        ram_q[i] <= '0;
                    end
                end else if (we && in_range && !is_rom) begin
                    ram_q[ram_addr] <= wdata;
                end
            end
        end else begin : g_no_ram
            logic unused_ok;
            assign unused_ok = &{1'b0, clk, rst_n, we, wdata, ram_page};
            assign ram_word  = '0;
        end
    endgenerate

    always_comb begin
        if (!in_range) begin
            rdata = '0;
        end else if (is_rom) begin
            rdata = rom_word;
        end else begin
            rdata = ram_word;
        end
    end

endmodule

// File: rtl/bank_router.sv
module bank_router
    import rtr_pkg::*;
#(
    parameter logic [RTR_AW-1:0] OWN_ID    = 16'h0003,
    parameter int                NUM_PAGES = 4,
    parameter int                ROM_PAGES = 1,
    parameter logic [RTR_DW-1:0] ROM_SEED  = 16'h5A3C
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic [15:0] cfg_bank_en,
    input  logic [15:0] cfg_bus_owner,
    input  logic [7:0]  cfg_page_sel,
    input  logic [8:0]  cfg_dev_count,
    input  logic        req_valid,
    output logic        req_ready,
    input  logic [15:0] req_src,
    input  logic [15:0] req_addr,
    input  logic        req_we,
    input  logic [15:0] req_wdata,
    output logic        rsp_valid,
    output logic [15:0] rsp_rdata,
    output logic        peer_req,
    output logic        peer_mem,
    output logic [7:0]  peer_idx,
    output logic [7:0]  peer_addr,
    output logic        peer_we,
    output logic [15:0] peer_wdata,
    input  logic        peer_ack,
    input  logic [15:0] peer_rdata
);

    rtr_regs_t         regs_d, regs_q;
    route_e            route;
    logic [RTR_BW-1:0] dec_page, dec_off, dec_pidx, dec_paddr;
    logic [RTR_DW-1:0] mem_rdata;
    logic              fire;
    logic              mem_we;

    rtr_decode #(.OWN_ID(OWN_ID)) u_decode (
        .src_id    (req_src),
        .addr      (req_addr),
        .bank_en   (cfg_bank_en),
        .bus_owner (cfg_bus_owner),
        .page_sel  (cfg_page_sel),
        .dev_count (cfg_dev_count),
        .route     (route),
        .page      (dec_page),
        .offset    (dec_off),
        .pidx      (dec_pidx),
        .paddr     (dec_paddr)
    );

    assign fire   = req_valid && (regs_q.st == ST_IDLE);
    assign mem_we = fire && req_we && (route == RT_LOCAL);

    rtr_local_mem #(
        .NUM_PAGES (NUM_PAGES),
        .ROM_PAGES (ROM_PAGES),
        .ROM_SEED  (ROM_SEED)
    ) u_mem (
        .clk    (clk),
        .rst_n  (rst_n),
        .we     (mem_we),
        .page   (dec_page),
        .offset (dec_off),
        .wdata  (req_wdata),
        .rdata  (mem_rdata)
    );

    always_comb begin
        regs_d           = regs_q;
        regs_d.rsp_valid = 1'b0;
        case (regs_q.st)
            ST_IDLE: begin
                if (fire) begin
                    case (route)
                        RT_LOCAL: begin
                            regs_d.rsp_valid = 1'b1;
                            regs_d.rsp_rdata = req_we ? '0 : mem_rdata;
                        end
                        RT_PCTRL, RT_PMEM: begin
                            regs_d.st         = ST_WAIT;
                            regs_d.peer_req   = 1'b1;
                            regs_d.peer_mem   = (route == RT_PMEM);
                            regs_d.peer_idx   = dec_pidx;
                            regs_d.peer_addr  = dec_paddr;
                            regs_d.peer_we    = req_we;
                            regs_d.peer_wdata = req_wdata;
                        end
                        default: begin
                            regs_d.rsp_valid = 1'b1;
                            regs_d.rsp_rdata = '0;
                        end
                    endcase
                end
            end
            ST_WAIT: begin
                if (peer_ack) begin
                    regs_d.st        = ST_IDLE;
                    regs_d.peer_req  = 1'b0;
                    regs_d.rsp_valid = 1'b1;
                    regs_d.rsp_rdata = regs_q.peer_we ? '0 : peer_rdata;
                end
            end
            default: regs_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            regs_q <= '0;
        end else begin
            regs_q <= regs_d;
        end
    end

    assign req_ready  = (regs_q.st == ST_IDLE);
    assign rsp_valid  = regs_q.rsp_valid;
    assign rsp_rdata  = regs_q.rsp_rdata;
    assign peer_req   = regs_q.peer_req;
    assign peer_mem   = regs_q.peer_mem;
    assign peer_idx   = regs_q.peer_idx;
    assign peer_addr  = regs_q.peer_addr;
    assign peer_we    = regs_q.peer_we;
    assign peer_wdata = regs_q.peer_wdata;

endmodule

// File: rtl/rtr_checker.sv
module rtr_checker
    import rtr_pkg::*;
#(
    parameter logic [15:0] OWN_ID = 16'h0003
) (
    input logic        clk,
    input logic        rst_n,
    input logic        req_valid,
    input logic        req_ready,
    input logic [15:0] req_src,
    input logic [15:0] cfg_bus_owner,
    input logic        rsp_valid,
    input logic [15:0] rsp_rdata,
    input logic        peer_req,
    input logic        peer_mem,
    input logic        peer_ack,
    input logic [7:0]  peer_idx,
    input logic [7:0]  peer_addr,
    input logic        peer_we,
    input logic [15:0] peer_wdata,
    input route_e      route
);

    // R10: pending peer access holds its request and fields until acknowledged
    a_r10_peer_hold: assert property (@(posedge clk) disable iff (!rst_n)
        peer_req && !peer_ack |=> peer_req && $stable(peer_idx) && $stable(peer_addr)
                                  && $stable(peer_we) && $stable(peer_wdata) && $stable(peer_mem));

    // R10: no new access is accepted while a peer access is pending
    a_r10_busy: assert property (@(posedge clk) disable iff (!rst_n)
        peer_req |-> !req_ready);

    // R10: acknowledge yields a response and ends the request
    a_r10_ack_resp: assert property (@(posedge clk) disable iff (!rst_n)
        peer_req && peer_ack |=> rsp_valid && !peer_req);

    // R10: forwarded routes start a peer request and give no immediate response
    a_r10_start: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && req_ready && (route == RT_PCTRL || route == RT_PMEM) |=> peer_req && !rsp_valid);

    // R6: foreign requesters get an immediate zero response
    a_r6_foreign_zero: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && req_ready && req_src != OWN_ID && req_src != cfg_bus_owner
        |=> rsp_valid && rsp_rdata == 16'h0000 && !peer_req);

    // R12: local accesses answer one cycle after acceptance
    a_r12_local_resp: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && req_ready && route == RT_LOCAL |=> rsp_valid && !peer_req);

    // R12: every response follows an acceptance or an acknowledge
    a_r12_rsp_cause: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rsp_valid) |-> $past(req_valid && req_ready) || $past(peer_req && peer_ack));

    // R2: control register numbers fit in four bits
    a_r2_ctrl_addr: assert property (@(posedge clk) disable iff (!rst_n)
        peer_req && !peer_mem |-> peer_addr[7:4] == 4'h0);

endmodule

bind bank_router rtr_checker #(.OWN_ID(OWN_ID)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .req_valid     (req_valid),
    .req_ready     (req_ready),
    .req_src       (req_src),
    .cfg_bus_owner (cfg_bus_owner),
    .rsp_valid     (rsp_valid),
    .rsp_rdata     (rsp_rdata),
    .peer_req      (peer_req),
    .peer_mem      (peer_mem),
    .peer_ack      (peer_ack),
    .peer_idx      (peer_idx),
    .peer_addr     (peer_addr),
    .peer_we       (peer_we),
    .peer_wdata    (peer_wdata),
    .route         (route)
);

// File: tb/bank_router_tb.sv
`timescale 1ns/1ps
module bank_router_tb;

    localparam logic [15:0] SELF  = 16'h0003;
    localparam logic [15:0] OWNR  = 16'h0009;
    localparam logic [15:0] FRGN  = 16'h0044;
    localparam logic [15:0] SEED  = 16'h5A3C;

    typedef struct packed {
        logic [15:0] ben;
        logic [15:0] src;
        logic [15:0] addr;
        logic        we;
        logic [15:0] wd;
        logic [1:0]  kind;   // 0 local or dropped, 1 peer control, 2 peer memory
        logic [15:0] exp;
        logic [3:0]  req;
    } vec_t;

    localparam int NV = 24;
    localparam vec_t VEC [NV] = '{
        '{16'h0007, SELF, 16'h0053, 1'b0, 16'h0000, 2'd1, 16'h0F03, 4'd2},  // R2
        '{16'h0007, SELF, 16'h0000, 1'b0, 16'h0000, 2'd1, 16'h0A00, 4'd2},  // R2 self slot
        '{16'h0007, SELF, 16'h0130, 1'b0, 16'h0000, 2'd1, 16'h1900, 4'd2},  // R2 last index
        '{16'h0007, SELF, 16'h0140, 1'b0, 16'h0000, 2'd0, 16'h0000, 4'd11}, // R11
        '{16'h0007, SELF, 16'h1234, 1'b0, 16'h0000, 2'd2, 16'hE234, 4'd3},  // R3
        '{16'h0007, SELF, 16'h1377, 1'b1, 16'hBEEF, 2'd2, 16'h0000, 4'd3},  // R3 write
        '{16'h0007, SELF, 16'h1400, 1'b0, 16'h0000, 2'd0, 16'h0000, 4'd3},  // R3 fallback
        '{16'h0007, SELF, 16'h2345, 1'b0, 16'h0000, 2'd0, 16'h0000, 4'd3},  // R3 fallback
        '{16'h0006, SELF, 16'h0155, 1'b1, 16'h1234, 2'd0, 16'h0000, 4'd4},  // R4
        '{16'h0006, SELF, 16'h0155, 1'b0, 16'h0000, 2'd0, 16'h1234, 4'd4},  // R4
        '{16'h0006, SELF, 16'h0210, 1'b0, 16'h0000, 2'd0, 16'h0000, 4'd8},  // R8
        '{16'h0006, SELF, 16'h0012, 1'b0, 16'h0000, 2'd0, 16'h5A2E, 4'd7},  // R7
        '{16'h0006, SELF, 16'h0012, 1'b1, 16'hFFFF, 2'd0, 16'h0000, 4'd7},  // R7
        '{16'h0006, SELF, 16'h0012, 1'b0, 16'h0000, 2'd0, 16'h5A2E, 4'd7},  // R7
        '{16'h0006, OWNR, 16'h7F20, 1'b1, 16'hCAFE, 2'd0, 16'h0000, 4'd5},  // R5
        '{16'h0006, SELF, 16'h0220, 1'b0, 16'h0000, 2'd0, 16'hCAFE, 4'd5},  // R5
        '{16'h0006, OWNR, 16'hFF20, 1'b0, 16'h0000, 2'd0, 16'hCAFE, 4'd5},  // R5
        '{16'h0006, FRGN, 16'h0220, 1'b1, 16'h1111, 2'd0, 16'h0000, 4'd6},  // R6
        '{16'h0006, FRGN, 16'h0220, 1'b0, 16'h0000, 2'd0, 16'h0000, 4'd6},  // R6
        '{16'h0006, SELF, 16'h0220, 1'b0, 16'h0000, 2'd0, 16'hCAFE, 4'd6},  // R6
        '{16'h0006, SELF, 16'h0455, 1'b1, 16'h7777, 2'd0, 16'h0000, 4'd9},  // R9
        '{16'h0006, SELF, 16'h0455, 1'b0, 16'h0000, 2'd0, 16'h0000, 4'd9},  // R9
        '{16'h0001, SELF, 16'h1234, 1'b0, 16'h0000, 2'd0, 16'h0000, 4'd1},  // R1
        '{16'h0004, SELF, 16'h0053, 1'b0, 16'h0000, 2'd0, 16'h5A6F, 4'd1}   // R1
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] cfg_bank_en = 16'h0000;
    logic [15:0] cfg_bus_owner = OWNR;
    logic [7:0]  cfg_page_sel = 8'h02;
    logic [8:0]  cfg_dev_count = 9'd20;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [15:0] req_src = 16'h0000;
    logic [15:0] req_addr = 16'h0000;
    logic        req_we = 1'b0;
    logic [15:0] req_wdata = 16'h0000;
    logic        rsp_valid;
    logic [15:0] rsp_rdata;
    logic        peer_req, peer_mem, peer_we;
    logic [7:0]  peer_idx, peer_addr;
    logic [15:0] peer_wdata;
    logic        peer_ack = 1'b0;
    logic [15:0] peer_rdata = 16'h0000;

    int checks = 0;
    int errors = 0;

    always #5 clk = ~clk;

    bank_router #(.OWN_ID(SELF), .NUM_PAGES(4), .ROM_PAGES(1), .ROM_SEED(SEED)) u_dut (
        .clk(clk), .rst_n(rst_n),
        .cfg_bank_en(cfg_bank_en), .cfg_bus_owner(cfg_bus_owner),
        .cfg_page_sel(cfg_page_sel), .cfg_dev_count(cfg_dev_count),
        .req_valid(req_valid), .req_ready(req_ready), .req_src(req_src),
        .req_addr(req_addr), .req_we(req_we), .req_wdata(req_wdata),
        .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
        .peer_req(peer_req), .peer_mem(peer_mem), .peer_idx(peer_idx),
        .peer_addr(peer_addr), .peer_we(peer_we), .peer_wdata(peer_wdata),
        .peer_ack(peer_ack), .peer_rdata(peer_rdata)
    );

    // Peer model: acknowledges two cycles after a request appears
    int pcnt = 0;
    always @(negedge clk) begin
        if (peer_ack) begin
            peer_ack <= 1'b0;
            pcnt     <= 0;
        end else if (peer_req) begin
            if (pcnt == 1) begin
                peer_ack   <= 1'b1;
                peer_rdata <= {peer_idx, peer_addr} ^ (peer_mem ? 16'hF000 : 16'h0A00);
            end
            pcnt <= pcnt + 1;
        end
    end

    task automatic chk(input string req, input string what, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    int          lat;
    logic        saw_peer, busy_ok;
    logic        p_mem, p_we;
    logic [7:0]  p_idx, p_addr;
    logic [15:0] p_wd, got;

    task automatic access(input logic [15:0] src, input logic [15:0] addr,
                          input logic we, input logic [15:0] wd);
        @(negedge clk);
        req_valid = 1'b1; req_src = src; req_addr = addr; req_we = we; req_wdata = wd;
        @(negedge clk);
        req_valid = 1'b0;
        lat = 1; saw_peer = 1'b0; busy_ok = 1'b1;
        p_mem = 1'b0; p_we = 1'b0; p_idx = '0; p_addr = '0; p_wd = '0;
        while (!rsp_valid && lat < 50) begin
            if (peer_req) begin
                saw_peer = 1'b1;
                p_mem = peer_mem; p_we = peer_we; p_idx = peer_idx;
                p_addr = peer_addr; p_wd = peer_wdata;
                if (req_ready) busy_ok = 1'b0;
            end
            @(negedge clk);
            lat++;
        end
        got = rsp_rdata;
    endtask

    initial begin
        #1_000_000;
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // Reset state
        chk("R12", "rsp_valid in reset", 16'(rsp_valid), 16'h0);
        chk("R10", "peer_req in reset", 16'(peer_req), 16'h0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R10", "ready after reset", 16'(req_ready), 16'h1);

        for (int i = 0; i < NV; i++) begin
            string tag;
            tag = $sformatf("R%0d", VEC[i].req);
            @(negedge clk);
            cfg_bank_en = VEC[i].ben;
            access(VEC[i].src, VEC[i].addr, VEC[i].we, VEC[i].wd);
            chk(tag, $sformatf("row %0d rdata", i), got, VEC[i].exp);
            chk(tag, $sformatf("row %0d peer used", i), 16'(saw_peer), 16'(VEC[i].kind != 2'd0));
            if (VEC[i].kind == 2'd0) begin
                chk("R12", $sformatf("row %0d latency", i), 16'(lat), 16'd1);
            end else begin
                chk("R10", $sformatf("row %0d latency", i), 16'(lat), 16'd3);
                chk("R10", $sformatf("row %0d ready low", i), 16'(busy_ok), 16'h1);
                chk(tag, $sformatf("row %0d peer_mem", i), 16'(p_mem), 16'(VEC[i].kind == 2'd2));
                chk(tag, $sformatf("row %0d peer_we", i), 16'(p_we), 16'(VEC[i].we));
                if (VEC[i].we) chk(tag, $sformatf("row %0d peer_wdata", i), p_wd, VEC[i].wd);
                if (VEC[i].kind == 2'd1) begin
                    chk(tag, $sformatf("row %0d peer_idx", i), 16'(p_idx), 16'(VEC[i].addr[11:4]));
                    chk(tag, $sformatf("row %0d peer_addr", i), 16'(p_addr), 16'(VEC[i].addr[3:0]));
                end else begin
                    chk(tag, $sformatf("row %0d peer_idx", i), 16'(p_idx), 16'(VEC[i].addr[15:8]));
                    chk(tag, $sformatf("row %0d peer_addr", i), 16'(p_addr), 16'(VEC[i].addr[7:0]));
                end
            end
        end

        // R8: reset clears RAM contents
        @(negedge clk);
        cfg_bank_en = 16'h0000;
        access(SELF, 16'h0300, 1'b1, 16'h4444);
        access(SELF, 16'h0300, 1'b0, 16'h0000);
        chk("R8", "RAM readback before reset", got, 16'h4444);
        @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        access(SELF, 16'h0300, 1'b0, 16'h0000);
        chk("R8", "RAM zero after reset", got, 16'h0000);

        // R5: page selection follows cfg_page_sel
        cfg_page_sel = 8'h03;
        access(OWNR, 16'h0011, 1'b1, 16'h9A9A);
        access(SELF, 16'h0311, 1'b0, 16'h0000);
        chk("R5", "owner page 3 write", got, 16'h9A9A);

        // R7: ROM read through the bus owner path
        cfg_page_sel = 8'h00;
        access(OWNR, 16'hAB80, 1'b0, 16'h0000);
        chk("R7", "ROM via owner", got, 16'h0080 ^ SEED);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule